// File: doc/BRIEF.md
# Dual-Clock Block RAM Model

This block is a synthesizable model of a simple dual-port block RAM with one clock for writing and another for reading. The write side has its own clock, clock enable, write enable, address and data input. The read side has its own clock, clock enable, output clock enable, reset, address and data output. The two clocks may run at any ratio to each other.

The read path is chosen when the block is built. In bypass form, the word is taken into a single read register and driven straight to the output. In pipelined form, a second output register, advanced by the output clock enable, adds one read-clock cycle. The read-side reset clears every read register. A build parameter makes this reset either synchronous to the read clock or asynchronous. The reset never touches the stored words. If the write side changes the word that the read side captures on the same cycle, the value read is undefined.

Top module: `dual_clock_bram`

## Requirements
- R1: With the default geometry (DATA_W=8, ADDR_W=11), the array holds 2048 independent 8-bit words, addressed 0 to 2047.
- R2: A word is stored only on a rising `wr_clk` edge where `wr_ce` and `wr_we` are both 1. If either is 0, the stored contents do not change.
- R3: In bypass form (READ_PIPE=0), a rising `rd_clk` edge with `rd_ce`=1 captures the word at `rd_addr`, and that word is on `rd_data` right after the same edge (one cycle of latency).
- R4: In pipelined form (READ_PIPE=1), with `rd_ce` and `rd_oce` held at 1, the word addressed before edge k is on `rd_data` after edge k+1. Each address in a run of consecutive addresses yields its own word, with none skipped or repeated.
- R5: In pipelined form, the output register loads only on edges where `rd_oce`=1. Otherwise `rd_data` holds its value.
- R6: While `rd_rst`=1, the read registers are cleared to 0. With ASYNC_RST=0 the clear takes effect at the next `rd_clk` edge. With ASYNC_RST=1 it takes effect at once, with no clock edge.
- R7: With `rd_ce`=0, the first read stage holds its word. The bypass output does not change, and the pipelined output settles on the last word captured.
- R8: In bypass form, `rd_oce` has no effect on `rd_data`.
- R9: Asserting `rd_rst` leaves the stored words intact. Reads after the reset return the data that was written before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_ce | input | 1 | Write-side clock enable |
| wr_we | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_clk | input | 1 | Read-side clock |
| rd_ce | input | 1 | Read-side clock enable (first read stage) |
| rd_oce | input | 1 | Output clock enable (pipeline register) |
| rd_rst | input | 1 | Read-side reset, active high |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data |

## Verification
The bench runs two instances side by side: a bypass instance with synchronous reset and a pipelined instance with asynchronous reset. It sweeps every address and compares each output against the same ramp, shifted by the expected latency. A design with one cycle too many or too few of latency would fail this comparison, and so would a design that repeats a byte and skips the next. Writes with only one of the two write enables high are aimed at a band of addresses; a model that ignored either enable would overwrite the ramp there. The bench also toggles the clock enable, the output clock enable and the reset in the middle of a run. It checks that each output holds or clears on exactly the edge the requirements give, and that the stored words survive the reset.

// File: rtl/bram_pkg.sv
package bram_pkg;

  typedef enum logic {
    RST_SYNC  = 1'b0,
    RST_ASYNC = 1'b1
  } rst_mode_e;

  // Number of read-clock edges from address capture to the output.
  function automatic int read_latency(input int pipe);
    return (pipe != 0) ? 2 : 1;
  endfunction

  // Words held by an array with the given address width.
  function automatic int word_count(input int addr_bits);
    return 1 << addr_bits;
  endfunction

  function automatic rst_mode_e pick_reset(input bit is_async);
    return is_async ? RST_ASYNC : RST_SYNC;
  endfunction

endpackage

// File: rtl/bram_store.sv
module bram_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 11
) (
  input  logic              wr_clk,
  input  logic              wr_ce,
  input  logic              wr_we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = bram_pkg::word_count(ADDR_W);

  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_fire;

  assign wr_fire = wr_ce & wr_we;

  always_ff @(posedge wr_clk) begin
    if (wr_fire) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_word = mem[rd_addr];

  // R2: a qualified write leaves its data at its address
  assert_write_lands_R2: assert property (@(posedge wr_clk)
    (wr_ce && wr_we) |=> mem[$past(wr_addr)] == $past(wr_data));

endmodule

// File: rtl/bram_out_reg.sv
module bram_out_reg #(
  parameter int                  DATA_W = 8,
  parameter bram_pkg::rst_mode_e MODE   = bram_pkg::RST_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  generate
    if (MODE == bram_pkg::RST_ASYNC) begin : g_async
      always_ff @(posedge clk or posedge rst) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
      end
    end
  endgenerate

  // R5 and R7: a stage with its enable low keeps its word
  assert_hold_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

  // R6: reset leaves zero at the following edge in either mode
  assert_reset_clears_R6: assert property (@(posedge clk)
    rst |=> q == '0);

endmodule

// File: rtl/dual_clock_bram.sv
module dual_clock_bram #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 11,
  parameter int READ_PIPE = 1,
  parameter bit ASYNC_RST = 1'b0
) (
  input  logic              wr_clk,
  input  logic              wr_ce,
  input  logic              wr_we,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_ce,
  input  logic              rd_oce,
  input  logic              rd_rst,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int                  READ_LAT = bram_pkg::read_latency(READ_PIPE);
  localparam bram_pkg::rst_mode_e RMODE    = bram_pkg::pick_reset(ASYNC_RST);

  logic [DATA_W-1:0] rd_word;   // array word at rd_addr
  logic [DATA_W-1:0] stage1_q;  // first read register

  bram_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wr_clk (wr_clk),
    .wr_ce  (wr_ce),
    .wr_we  (wr_we),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_addr(rd_addr),
    .rd_word(rd_word)
  );

  bram_out_reg #(.DATA_W(DATA_W), .MODE(RMODE)) u_stage1 (
    .clk(rd_clk),
    .rst(rd_rst),
    .en (rd_ce),
    .d  (rd_word),
    .q  (stage1_q)
  );

  generate
    if (READ_LAT == 2) begin : g_pipe
      logic [DATA_W-1:0] stage2_q;
      bram_out_reg #(.DATA_W(DATA_W), .MODE(RMODE)) u_stage2 (
        .clk(rd_clk),
        .rst(rd_rst),
        .en (rd_oce),
        .d  (stage1_q),
        .q  (stage2_q)
      );
      assign rd_data = stage2_q;

      // R4: output register takes the first-stage word when enabled
      assert_pipe_follows_R4: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_oce |=> rd_data == $past(stage1_q));
    end else begin : g_bypass
      assign rd_data = stage1_q;
    end
  endgenerate

  // R3: the captured word is the array word addressed at the enabled edge
  // (assumes no write to that address on the same cycle)
  assert_capture_latency_R3: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_ce |=> stage1_q == $past(rd_word));

endmodule

// File: tb/sim_dual_clock_bram.sv
module sim_dual_clock_bram;
  localparam int DW = 8;
  localparam int AW = 11;
  localparam int N  = 1 << AW;

  logic          wr_clk = 1'b0;
  logic          rd_clk = 1'b0;
  logic          wr_ce = 1'b0, wr_we = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_ce = 1'b1, rd_oce = 1'b1, rd_rst = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] q_byp, q_pip;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 wr_clk = ~wr_clk;   // 50 MHz write clock
  always #13 rd_clk = ~rd_clk;   // unrelated read clock

  // bypass, synchronous reset
  dual_clock_bram #(.DATA_W(DW), .ADDR_W(AW), .READ_PIPE(0), .ASYNC_RST(1'b0)) u0 (
    .wr_clk(wr_clk), .wr_ce(wr_ce), .wr_we(wr_we), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_ce(rd_ce), .rd_oce(rd_oce), .rd_rst(rd_rst), .rd_addr(rd_addr),
    .rd_data(q_byp));

  // pipelined, asynchronous reset
  dual_clock_bram #(.DATA_W(DW), .ADDR_W(AW), .READ_PIPE(1), .ASYNC_RST(1'b1)) u1 (
    .wr_clk(wr_clk), .wr_ce(wr_ce), .wr_we(wr_we), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rd_ce(rd_ce), .rd_oce(rd_oce), .rd_rst(rd_rst), .rd_addr(rd_addr),
    .rd_data(q_pip));

  function automatic logic [DW-1:0] ramp(input int a);
    return DW'((a * 7 + 3) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd_step();
    @(negedge rd_clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R6: reset state on both outputs
    rd_step();
    check(q_byp == 0, "R6 reset byp", q_byp, 0);
    check(q_pip == 0, "R6 reset pip", q_pip, 0);

    // R1: fill the full array with a ramp
    for (int a = 0; a < N; a++) begin
      @(negedge wr_clk);
      wr_ce = 1'b1; wr_we = 1'b1; wr_addr = AW'(a); wr_data = ramp(a);
    end
    // R2: half-enabled writes must not land
    for (int a = 0; a < 128; a++) begin
      @(negedge wr_clk);
      wr_ce = (a >= 64); wr_we = (a < 64); wr_addr = AW'(a); wr_data = ~ramp(a);
    end
    @(negedge wr_clk);
    wr_ce = 1'b0; wr_we = 1'b0;
    @(negedge wr_clk);

    // R3/R4: sweep every address
    rd_step();
    rd_rst = 1'b0; rd_addr = '0;
    for (int i = 1; i <= N; i++) begin
      rd_step();
      check(q_byp == ramp(i-1), (i <= 128) ? "R2 R3 byp" : "R1 R3 byp", q_byp, ramp(i-1));
      if (i >= 2)
        check(q_pip == ramp(i-2), "R4 pip", q_pip, ramp(i-2));
      if (i < N) rd_addr = AW'(i);
    end
    rd_step();
    check(q_pip == ramp(N-1), "R1 R4 pip top", q_pip, ramp(N-1));

    // R7: clock enable low holds
    rd_addr = 5;
    rd_step();
    rd_ce = 1'b0; rd_addr = 9;
    rd_step();
    check(q_byp == ramp(5), "R7 byp hold", q_byp, ramp(5));
    check(q_pip == ramp(5), "R7 pip settle", q_pip, ramp(5));
    rd_step();
    check(q_byp == ramp(5), "R7 byp hold2", q_byp, ramp(5));
    check(q_pip == ramp(5), "R7 pip hold2", q_pip, ramp(5));

    // R5/R8: output clock enable
    rd_ce = 1'b1; rd_addr = 20;
    rd_step(); rd_step();
    check(q_pip == ramp(20), "R5 pip load", q_pip, ramp(20));
    rd_oce = 1'b0;
    for (int k = 21; k <= 23; k++) begin
      rd_addr = AW'(k);
      rd_step();
      check(q_pip == ramp(20), "R5 pip hold", q_pip, ramp(20));
      check(q_byp == ramp(k), "R8 byp ignores oce", q_byp, ramp(k));
    end
    rd_oce = 1'b1;
    rd_step();
    check(q_pip == ramp(23), "R5 pip resume", q_pip, ramp(23));

    // R6: sync clears at edge, async at once
    rd_rst = 1'b1;
    #2;
    check(q_pip == 0, "R6 async immediate", q_pip, 0);
    check(q_byp == ramp(23), "R6 sync waits", q_byp, ramp(23));
    rd_step();
    check(q_byp == 0, "R6 sync cleared", q_byp, 0);
    check(q_pip == 0, "R6 async held", q_pip, 0);

    // R9: contents survive reset
    rd_rst = 1'b0; rd_addr = 0;
    for (int i = 1; i <= 40; i++) begin
      rd_step();
      check(q_byp == ramp(i-1), "R9 byp", q_byp, ramp(i-1));
      if (i >= 2) check(q_pip == ramp(i-2), "R9 pip", q_pip, ramp(i-2));
      rd_addr = AW'(i);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule